// File: doc/BRIEF.md
# UART Receive Queue and Interrupt Flag Unit

This block sits between the serial shifters of a UART and the CPU register interface. It keeps received bytes in a small first-in first-out queue of two entries. Each entry stores the byte together with its framing and parity error status. The block also holds the seven interrupt flags and their enable bits. Every flag has its own set and clear rule, and several of them clear as a side effect of a data read or a data write rather than only through a write-1-to-clear access.

The receive shifter reports each finished byte with a one-cycle strobe. The transmit side reports when its shift register takes the buffered byte, and when a stop bit has gone out. The CPU side issues one-cycle strobes for a data read, a transmit data write, a flag clear write, an enable write and a software reset. The oldest buffered byte is always visible on the data output, and one interrupt request combines the enabled flags.

Top module: `uart_rxbuf_irq`

## Requirements
- R1: After reset, `flags` reads 0x20 (only transmit-empty set), `rd_byte` is 0, the queue is empty and all enable bits are 0, so `irq` is 0.
- R2: `rd_byte` shows the oldest held byte, and reads as 0 while the queue is empty. A read with `rd_data` removes that byte, so bytes come out in arrival order.
- R3: Flag bit 0 (one-byte-full) is 1 while at least one byte is held. It clears only when a read leaves the queue empty.
- R4: Flag bit 1 (two-bytes-full) sets when a byte arrives while one byte is already held, and clears on a read. It is never 1 while bit 0 is 0.
- R5: A byte that finishes while two bytes are held and no read occurs in that cycle sets flag bit 2 (overrun). That byte is discarded and the held bytes stay unchanged. A read and an arrival in the same cycle on a full queue accept the new byte with no overrun.
- R6: Overrun is cleared only by writing 1 to bit 2 or by software reset. Reads leave it set. Writing 1 to bits 0, 1 or 5 has no effect.
- R7: Flag bit 3 (framing) and bit 4 (parity) set when an accepted byte carries that error. Each clears on a write of 1 to it, or when the byte that carried the error is read out.
- R8: Flag bit 5 (transmit-empty) sets on `tx_load` and clears on `wr_txdata`. When both occur in the same cycle, it ends up set.
- R9: Flag bit 6 (end of transmission) sets on `stop_sent` only when bit 5 is 1 in that cycle. It clears on a write of 1.
- R10: When a hardware set event and a write-1 clear reach the same flag in one cycle, the flag ends up set.
- R11: `irq` is 1 exactly while some flag and its enable bit (same bit position, loaded by `wr_ien`) are both 1.
- R12: `soft_rst` empties the queue and returns the flags to 0x20. It overrides any event in the same cycle and keeps the enable bits.
- R13: A read while the queue is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software reset strobe |
| rx_done | input | 1 | Receive shift complete strobe |
| rx_byte | input | 8 | Received byte |
| rx_ferr | input | 1 | Framing error of the received byte |
| rx_perr | input | 1 | Parity error of the received byte |
| tx_load | input | 1 | Transmit shift register took the buffered byte |
| stop_sent | input | 1 | Stop bit finished sending |
| rd_data | input | 1 | CPU read of received data |
| wr_txdata | input | 1 | CPU write of transmit data |
| wr_flags | input | 1 | CPU write-1-to-clear strobe for flags |
| wr_val | input | 7 | Write-1-to-clear mask |
| wr_ien | input | 1 | CPU write strobe for enable bits |
| ien_val | input | 7 | New enable bits |
| rd_byte | output | 8 | Oldest held byte |
| flags | output | 7 | Flag vector: bit 0 one-full, 1 two-full, 2 overrun, 3 framing, 4 parity, 5 transmit-empty, 6 end of transmission |
| irq | output | 1 | Combined interrupt request |

## Verification
Several functions can collide in one cycle. The bench forces each collision with a single stimulus cycle and checks the outcome one cycle later. A read and a new arrival on a full queue must accept the new byte with no overrun, and the read byte's parity flag must clear. A hardware overrun and a write-1 clear of the overrun bit must leave the flag set. A load of the transmit shift register and a transmit data write must leave transmit-empty set. A software reset together with an arrival must leave the queue empty.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int DATA_W = 8;
  localparam int FLAG_W = 7;

  localparam int F_RX1  = 0;
  localparam int F_RX2  = 1;
  localparam int F_OVR  = 2;
  localparam int F_FERR = 3;
  localparam int F_PERR = 4;
  localparam int F_TBE  = 5;
  localparam int F_TEND = 6;

  localparam logic [FLAG_W-1:0] FLAG_INIT = FLAG_W'(1) << F_TBE;
  localparam logic [FLAG_W-1:0] W1C_MASK  = (FLAG_W'(1) << F_OVR) | (FLAG_W'(1) << F_FERR)
                                          | (FLAG_W'(1) << F_PERR) | (FLAG_W'(1) << F_TEND);

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              ferr;
    logic              perr;
  } rx_entry_t;
endpackage

// File: rtl/uart_rb_fifo.sv
module uart_rb_fifo
  import uart_rb_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  rx_entry_t     din,
  output rx_entry_t     head,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);
  rx_entry_t     mem [DEPTH];
  logic [PW-1:0] wr_ptr, wr_ptr_n;
  logic [PW-1:0] rd_ptr, rd_ptr_n;
  logic [CW-1:0] cnt_q;

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    cnt_nxt  = cnt_q;
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      cnt_nxt  = '0;
    end else begin
      if (push) wr_ptr_n = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      if (pop)  rd_ptr_n = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      case ({push, pop})
        2'b10:   cnt_nxt = cnt_q + CW'(1);
        2'b01:   cnt_nxt = cnt_q - CW'(1);
        default: cnt_nxt = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      cnt_q  <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  assign head = mem[rd_ptr];
  assign cnt  = cnt_q;
endmodule

// File: rtl/uart_rb_flags.sv
module uart_rb_flags #(
  parameter int N = 7,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_clr,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q, bit_d, bit_en;

    always_comb begin
      bit_en = soft_clr | set[i] | clr[i];
      if (soft_clr)    bit_d = INIT[i];
      else if (set[i]) bit_d = 1'b1;
      else             bit_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= INIT[i];
      else if (bit_en) bit_q <= bit_d;
    end

    assign q[i] = bit_q;
  end
endmodule

// File: rtl/uart_rxbuf_irq.sv
module uart_rxbuf_irq
  import uart_rb_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_ferr,
  input  logic              rx_perr,
  input  logic              tx_load,
  input  logic              stop_sent,
  input  logic              rd_data,
  input  logic              wr_txdata,
  input  logic              wr_flags,
  input  logic [FLAG_W-1:0] wr_val,
  input  logic              wr_ien,
  input  logic [FLAG_W-1:0] ien_val,
  output logic [DATA_W-1:0] rd_byte,
  output logic [FLAG_W-1:0] flags,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);

  rx_entry_t     in_ent, head;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          empty, full, pop, accept, ovr_evt;
  logic [FLAG_W-1:0] f_set, f_clr, w1c, en_q, en_d;

  always_comb begin
    empty   = (cnt == '0);
    full    = (cnt == CW'(DEPTH));
    pop     = rd_data & ~empty & ~soft_rst;
    accept  = rx_done & (~full | pop) & ~soft_rst;
    ovr_evt = rx_done & full & ~pop & ~soft_rst;
    in_ent  = '{data: rx_byte, ferr: rx_ferr, perr: rx_perr};
  end

  uart_rb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (soft_rst),
    .push    (accept),
    .pop     (pop),
    .din     (in_ent),
    .head    (head),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt)
  );

  always_comb begin
    w1c = wr_flags ? (wr_val & W1C_MASK) : '0;

    f_set         = '0;
    f_set[F_RX1]  = (cnt_nxt != '0);
    f_set[F_RX2]  = (cnt_nxt == CW'(DEPTH));
    f_set[F_OVR]  = ovr_evt;
    f_set[F_FERR] = accept & rx_ferr;
    f_set[F_PERR] = accept & rx_perr;
    f_set[F_TBE]  = tx_load;
    f_set[F_TEND] = stop_sent & flags[F_TBE];

    f_clr         = w1c;
    f_clr[F_RX1]  = pop;
    f_clr[F_RX2]  = pop;
    f_clr[F_FERR] = w1c[F_FERR] | (pop & head.ferr);
    f_clr[F_PERR] = w1c[F_PERR] | (pop & head.perr);
    f_clr[F_TBE]  = wr_txdata;
  end

  uart_rb_flags #(.N(FLAG_W), .INIT(FLAG_INIT)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_rst),
    .set      (f_set),
    .clr      (f_clr),
    .q        (flags)
  );

  always_comb en_d = wr_ien ? ien_val : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign irq     = |(flags & en_q);
  assign rd_byte = empty ? '0 : head.data;
endmodule

// File: rtl/uart_rxbuf_irq_chk.sv
module uart_rxbuf_irq_chk
  import uart_rb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              rx_done,
  input logic              rd_data,
  input logic              tx_load,
  input logic              w1c_ovr,
  input logic [DATA_W-1:0] rd_byte,
  input logic [FLAG_W-1:0] flags,
  input logic              irq
);
  // R5: arrival on a full queue without a read raises overrun
  assert_overrun_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[F_RX2] && rx_done && !rd_data && !soft_rst) |=> flags[F_OVR]);

  // R5: discarded byte leaves the head untouched
  assert_overrun_keeps_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[F_RX2] && rx_done && !rd_data && !soft_rst) |=> $stable(rd_byte));

  assert_two_implies_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flags[F_RX2] |-> flags[F_RX1]);

  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[F_OVR] && !soft_rst && !w1c_ovr) |=> flags[F_OVR]);

  assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));

  assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (flags == FLAG_INIT && rd_byte == '0));

  assert_tx_load_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !soft_rst) |=> flags[F_TBE]);

  assert_empty_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[F_RX1] |-> (rd_byte == '0));
endmodule

bind uart_rxbuf_irq uart_rxbuf_irq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .soft_rst (soft_rst),
  .rx_done  (rx_done),
  .rd_data  (rd_data),
  .tx_load  (tx_load),
  .w1c_ovr  (wr_flags & wr_val[uart_rb_pkg::F_OVR]),
  .rd_byte  (rd_byte),
  .flags    (flags),
  .irq      (irq)
);

// File: tb/uart_rxbuf_irq_tb.sv
module uart_rxbuf_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0, rx_done = 1'b0, rx_ferr = 1'b0, rx_perr = 1'b0;
  logic       tx_load = 1'b0, stop_sent = 1'b0, rd_data = 1'b0, wr_txdata = 1'b0;
  logic       wr_flags = 1'b0, wr_ien = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [6:0] wr_val = 7'h00, ien_val = 7'h00;
  logic [7:0] rd_byte;
  logic [6:0] flags;
  logic       irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [6:0] f;
    logic [7:0] b;
    logic       i;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  uart_rxbuf_irq u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rx_done(rx_done),
    .rx_byte(rx_byte), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .tx_load(tx_load),
    .stop_sent(stop_sent), .rd_data(rd_data), .wr_txdata(wr_txdata),
    .wr_flags(wr_flags), .wr_val(wr_val), .wr_ien(wr_ien), .ien_val(ien_val),
    .rd_byte(rd_byte), .flags(flags), .irq(irq)
  );

  task automatic compare(input exp_t e);
    total++;
    if (flags !== e.f || rd_byte !== e.b || irq !== e.i) begin
      bad++;
      $display("FAIL %s: flags=%h byte=%h irq=%b expected flags=%h byte=%h irq=%b",
               e.tag, flags, rd_byte, irq, e.f, e.b, e.i);
    end
  endtask

  // driver: stimulus already set; wait one edge, release strobes, push expectation
  task automatic step(input logic [6:0] f, input logic [7:0] b, input logic i, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    soft_rst = 0; rx_done = 0; rx_ferr = 0; rx_perr = 0; tx_load = 0;
    stop_sent = 0; rd_data = 0; wr_txdata = 0; wr_flags = 0; wr_ien = 0;
    e.f = f; e.b = b; e.i = i; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic rx(input logic [7:0] d, input logic fe, input logic pe);
    rx_done = 1; rx_byte = d; rx_ferr = fe; rx_perr = pe;
  endtask

  // monitor: mid-cycle, compare the state produced by the last edge
  initial begin
    forever begin
      @(posedge clk);
      #4;
      if (sb.size() > 0) compare(sb.pop_front());
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_t r;
    #22 rst_n = 1;
    @(posedge clk); #4;
    r.f = 7'h20; r.b = 8'h00; r.i = 1'b0; r.tag = "R1 reset state";
    compare(r);
    #1;
    rx(8'h11, 0, 0);             step(7'h21, 8'h11, 0, "R3 R2 first byte");
    rx(8'h22, 1, 0);             step(7'h2B, 8'h11, 0, "R4 R7 second byte framing");
    rx(8'h33, 0, 0);             step(7'h2F, 8'h11, 0, "R5 overrun discards");
    rd_data = 1;                 step(7'h2D, 8'h22, 0, "R2 R4 R6 read oldest");
    rd_data = 1;                 step(7'h24, 8'h00, 0, "R7 R3 read clears framing");
    rd_data = 1;                 step(7'h24, 8'h00, 0, "R13 read on empty");
    wr_flags = 1; wr_val = 7'h25; step(7'h20, 8'h00, 0, "R6 w1c overrun only");
    rx(8'h44, 0, 1);             step(7'h31, 8'h44, 0, "R7 parity byte");
    rx(8'h55, 0, 0);             step(7'h33, 8'h44, 0, "R4 full");
    rx(8'h66, 0, 0); rd_data = 1; step(7'h23, 8'h55, 0, "R5 R7 read and arrive");
    rx(8'h77, 0, 0); wr_flags = 1; wr_val = 7'h04;
                                 step(7'h27, 8'h55, 0, "R10 set beats clear");
    rd_data = 1;                 step(7'h25, 8'h66, 0, "R2 second read");
    rd_data = 1;                 step(7'h24, 8'h00, 0, "R3 empty again");
    wr_txdata = 1;               step(7'h04, 8'h00, 0, "R8 tx write clears");
    stop_sent = 1;               step(7'h04, 8'h00, 0, "R9 no end while busy");
    tx_load = 1; wr_txdata = 1;  step(7'h24, 8'h00, 0, "R8 load beats write");
    stop_sent = 1;               step(7'h64, 8'h00, 0, "R9 end of transmission");
    wr_flags = 1; wr_val = 7'h40; step(7'h24, 8'h00, 0, "R9 w1c end");
    wr_ien = 1; ien_val = 7'h04; step(7'h24, 8'h00, 1, "R11 enabled overrun");
    wr_flags = 1; wr_val = 7'h04; step(7'h20, 8'h00, 0, "R11 irq drops");
    rx(8'h88, 0, 0);             step(7'h21, 8'h88, 0, "R11 not enabled");
    wr_ien = 1; ien_val = 7'h01; step(7'h21, 8'h88, 1, "R11 enable one-full");
    soft_rst = 1;                step(7'h20, 8'h00, 0, "R12 soft reset");
    rx(8'hAA, 0, 0);             step(7'h21, 8'hAA, 1, "R12 enables kept");
    rx(8'hBB, 1, 1); soft_rst = 1; step(7'h20, 8'h00, 0, "R12 reset beats arrival");
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule